// File: doc/BRIEF.md
# SPI Serial Engine with Sticky Status Flags

This block is an SPI serial engine that works as either master or slave. Software reaches it through a small register port with four word addresses: control, status, data and clock count. In master mode, a write to the data register starts a transfer. The engine drives SCK from a divided peripheral clock, shifts the word out most significant bit first on the master output, and samples the master input on each rising SCK edge. In slave mode, the engine samples the incoming serial data on rising edges of the external SCK while the select input is low. Between words it shifts its loaded word out on the slave output.

Five status conditions are sticky: transfer complete, write collision, read overrun, mode fault and slave abort. Each clears only through its own ordered sequence of bus accesses. While a word is in flight, or while a finished word has not been acknowledged, a data write is refused and leaves the engine untouched. This lets software tell a lost write from a delivered one.

Top module: `spi_flag_engine`

## Requirements
- R1: After reset, every status flag is 0, the data and control registers read 0, and SCK is low.
- R2: With control bit 5 set (master), an accepted data write sends the word MSB first on `mosiOut`, with one rising SCK edge per bit. The transfer-complete flag (status bit 7) reads 1 from exactly word length × effective period + 1 cycles after the write edge, and not one cycle earlier.
- R3: The word length is 8 when control bit 2 is 0. When control bit 2 is 1, control bits 11:8 select the length: 1000 to 1111 give 8 to 15 bits, 0000 gives 16 bits, and 0001 to 0111 give 8 bits. Received data reads right-aligned in the data register (address 2), and all unused upper bits read 0.
- R4: The effective SCK period is the clock-count register (address 3) rounded down to even, with a floor of 8 peripheral clocks. SCK is high for half of that period in each bit.
- R5: A data write made while a word is in flight, or while the transfer-complete flag is set and not yet acknowledged, is discarded: no transfer starts and the transmit word is unchanged. Such a write sets the write-collision flag (status bit 6).
- R6: The transfer-complete and write-collision flags clear only when a status read (address 1) that saw them set is followed by a data register read or write. A data access without that prior status read leaves both flags set.
- R7: If a word finishes while the transfer-complete flag is still set, the read-overrun flag (status bit 5) is set and the earlier received word is kept. The read-overrun flag clears on a status read alone.
- R8: If select goes low while in master mode, the mode-fault flag (status bit 4) is set, control bit 5 is cleared and any transfer is dropped. The flag clears only when a status read is followed by a control write; a data access does not clear it.
- R9: In slave mode, a word is sampled from `mosiIn` on the rising `sckIn` edges while `selN` is low. The transfer-complete flag is set after the last sampling edge. `misoOut` presents the loaded word MSB first, advancing on each falling edge.
- R10: In slave mode, releasing `selN` in the middle of a word sets the slave-abort flag (status bit 3) and restarts bit counting. The flag clears on a status read alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access strobe, one cycle |
| busWr | input | 1 | Write qualifier |
| busRd | input | 1 | Read qualifier (a read has side effects) |
| busAddr | input | 2 | 0 control, 1 status, 2 data, 3 clock count |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for the addressed register, combinational |
| sckOut | output | 1 | Master serial clock, idle low |
| mosiOut | output | 1 | Master serial data out |
| misoIn | input | 1 | Master serial data in |
| sckIn | input | 1 | Slave serial clock in |
| mosiIn | input | 1 | Slave serial data in |
| misoOut | output | 1 | Slave serial data out |
| selN | input | 1 | Active-low select, input in both modes |

## Verification
Register reads are combinational, so a read shows the state before the edge that takes it. The bench samples read data late in the low half of the clock. In master mode the flag rises on the clock after the last falling SCK edge, which is length × period + 1 edges after the write. The bench therefore reads status one cycle before that edge and again one cycle after it. Slave inputs pass through a three-stage synchronizer, so the slave flags settle within five clocks of a pin change. The bench holds each pin level for four clocks and reads status only after the final hold.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int WORD_W = 16;
  localparam int BITS_W = $clog2(WORD_W + 1);

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_CCNT = 2'd3;

  localparam int WIDE_BIT   = 2;
  localparam int MASTER_BIT = 5;
  localparam logic [11:0] CTRL_KEEP = 12'hF24;

  // control to datapath
  typedef struct packed {
    logic              startMaster;
    logic              loadTx;
    logic              abortXfer;
    logic [WORD_W-1:0] txWord;
  } dpStrobe_t;

  // datapath to control
  typedef struct packed {
    logic              wordDone;
    logic              slaveAbort;
    logic              modeFaultDet;
    logic              busy;
    logic [WORD_W-1:0] rxWord;
  } dpEvent_t;

  function automatic logic [BITS_W-1:0] wordBits(logic wideEn, logic [3:0] lenField);
    if (!wideEn)              return BITS_W'(8);
    else if (lenField == 4'd0) return BITS_W'(WORD_W);
    else if (lenField[3])     return BITS_W'(lenField);
    else                      return BITS_W'(8);
  endfunction
endpackage

// File: rtl/spi_flag_datapath.sv
module spi_flag_datapath
  import spi_flag_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int SYNC_N = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              cfgMaster,
  input  logic [BITS_W-1:0] cfgBits,
  input  logic [CNT_W-1:0]  cfgHalf,
  output dpEvent_t          evt,
  output logic              sckOut,
  output logic              mosiOut,
  output logic              misoOut,
  input  logic              misoIn,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              selN
);
  logic [SYNC_N-1:0] sckSync, mosiSync, selSync;
  logic sckS, sckPrev, mosiS, selS, selPrev;
  logic sckRise, sckFall, selRise;

  logic [WORD_W-1:0] shiftReg, rxShift, rxWordQ, alignedTx, slvRxNext;
  logic [WORD_W-2:0] keepBits;
  logic [BITS_W-1:0] bitCnt, lenQ;
  logic [CNT_W-1:0]  phaseCnt, halfQ;
  logic busyM, sckLvl, wordDoneQ, abortQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckSync  <= '0;
      mosiSync <= '0;
      selSync  <= '1;
    end else begin
      sckSync  <= {sckSync[SYNC_N-2:0], sckIn};
      mosiSync <= {mosiSync[SYNC_N-2:0], mosiIn};
      selSync  <= {selSync[SYNC_N-2:0], selN};
    end
  end

  assign sckS    = sckSync[SYNC_N-2];
  assign sckPrev = sckSync[SYNC_N-1];
  assign mosiS   = mosiSync[SYNC_N-2];
  assign selS    = selSync[SYNC_N-2];
  assign selPrev = selSync[SYNC_N-1];
  assign sckRise = sckS & ~sckPrev;
  assign sckFall = ~sckS & sckPrev;
  assign selRise = selS & ~selPrev;

  assign alignedTx = strobe.txWord << (BITS_W'(WORD_W) - cfgBits);

  always_comb begin
    keepBits  = (bitCnt == '0) ? '0 : rxShift[WORD_W-2:0];
    slvRxNext = {keepBits, mosiS};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      rxShift   <= '0;
      rxWordQ   <= '0;
      bitCnt    <= '0;
      lenQ      <= BITS_W'(8);
      phaseCnt  <= '0;
      halfQ     <= CNT_W'(4);
      busyM     <= 1'b0;
      sckLvl    <= 1'b0;
      wordDoneQ <= 1'b0;
      abortQ    <= 1'b0;
    end else begin
      wordDoneQ <= 1'b0;
      abortQ    <= 1'b0;
      if (strobe.abortXfer) begin
        busyM  <= 1'b0;
        sckLvl <= 1'b0;
        bitCnt <= '0;
      end else if (strobe.startMaster) begin
        busyM    <= 1'b1;
        sckLvl   <= 1'b0;
        phaseCnt <= '0;
        bitCnt   <= '0;
        lenQ     <= cfgBits;
        halfQ    <= cfgHalf;
        shiftReg <= alignedTx;
        rxShift  <= '0;
      end else if (busyM) begin
        if (phaseCnt == halfQ - CNT_W'(1)) begin
          phaseCnt <= '0;
          if (!sckLvl) begin
            sckLvl  <= 1'b1;
            rxShift <= {rxShift[WORD_W-2:0], misoIn};
          end else begin
            sckLvl <= 1'b0;
            if (bitCnt == lenQ - BITS_W'(1)) begin
              busyM     <= 1'b0;
              wordDoneQ <= 1'b1;
              rxWordQ   <= rxShift;
              bitCnt    <= '0;
            end else begin
              bitCnt   <= bitCnt + BITS_W'(1);
              shiftReg <= shiftReg << 1;
            end
          end
        end else begin
          phaseCnt <= phaseCnt + CNT_W'(1);
        end
      end else if (!cfgMaster) begin
        if (strobe.loadTx) shiftReg <= alignedTx;
        else if (!selS && sckFall && bitCnt != '0) shiftReg <= shiftReg << 1;
        if (selRise && bitCnt != '0) begin
          abortQ <= 1'b1;
          bitCnt <= '0;
        end else if (!selS && sckRise) begin
          rxShift <= slvRxNext;
          if (bitCnt == cfgBits - BITS_W'(1)) begin
            wordDoneQ <= 1'b1;
            rxWordQ   <= slvRxNext;
            bitCnt    <= '0;
          end else begin
            bitCnt <= bitCnt + BITS_W'(1);
          end
        end
      end
    end
  end

  assign sckOut  = sckLvl;
  assign mosiOut = cfgMaster & shiftReg[WORD_W-1];
  assign misoOut = ~cfgMaster & shiftReg[WORD_W-1];

  assign evt.wordDone     = wordDoneQ;
  assign evt.slaveAbort   = abortQ;
  assign evt.modeFaultDet = cfgMaster & ~selS;
  assign evt.busy         = cfgMaster ? busyM : (bitCnt != '0);
  assign evt.rxWord       = rxWordQ;

  // R4
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyM |-> (phaseCnt < halfQ));

  // R2
  master_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busyM) && !$past(strobe.abortXfer)) |-> wordDoneQ);

  // R10
  abort_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortQ |-> (bitCnt == '0));
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [1:0]        busAddr,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  input  dpEvent_t          evt,
  output dpStrobe_t         strobe,
  output logic              cfgMaster,
  output logic [BITS_W-1:0] cfgBits,
  output logic [CNT_W-1:0]  cfgHalf
);
  localparam logic [CNT_W-1:0] MIN_PERIOD = CNT_W'(8);

  logic [11:0]       ctrlReg;
  logic [CNT_W-1:0]  clkCnt, evenCnt, effPeriod;
  logic [WORD_W-1:0] rxData;
  logic doneFlag, wcolFlag, ovrFlag, modfFlag, abrtFlag;
  logic seenDone, seenWcol, seenModf;
  logic statusRd, dataRd, dataWr, dataAcc, ctrlWr, cntWr, blockedWr, okWr;

  assign statusRd  = busSel & busRd & (busAddr == ADDR_STAT);
  assign dataRd    = busSel & busRd & (busAddr == ADDR_DATA);
  assign dataWr    = busSel & busWr & (busAddr == ADDR_DATA);
  assign ctrlWr    = busSel & busWr & (busAddr == ADDR_CTRL);
  assign cntWr     = busSel & busWr & (busAddr == ADDR_CCNT);
  assign dataAcc   = dataRd | dataWr;
  assign blockedWr = dataWr & (evt.busy | (doneFlag & ~seenDone));
  assign okWr      = dataWr & ~blockedWr;

  assign cfgMaster = ctrlReg[MASTER_BIT];
  assign cfgBits   = wordBits(ctrlReg[WIDE_BIT], ctrlReg[11:8]);
  assign evenCnt   = {clkCnt[CNT_W-1:1], 1'b0};
  assign effPeriod = (clkCnt < MIN_PERIOD) ? MIN_PERIOD : evenCnt;
  assign cfgHalf   = effPeriod >> 1;

  assign strobe.startMaster = okWr & cfgMaster;
  assign strobe.loadTx      = okWr & ~cfgMaster;
  assign strobe.abortXfer   = evt.modeFaultDet;
  assign strobe.txWord      = busWdata;

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      ADDR_CTRL: busRdata = WORD_W'(ctrlReg);
      ADDR_STAT: busRdata = WORD_W'({doneFlag, wcolFlag, ovrFlag, modfFlag, abrtFlag, 3'b000});
      ADDR_DATA: busRdata = rxData;
      default:   busRdata = WORD_W'(clkCnt);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      clkCnt   <= '0;
      rxData   <= '0;
      doneFlag <= 1'b0;
      wcolFlag <= 1'b0;
      ovrFlag  <= 1'b0;
      modfFlag <= 1'b0;
      abrtFlag <= 1'b0;
      seenDone <= 1'b0;
      seenWcol <= 1'b0;
      seenModf <= 1'b0;
    end else begin
      if (ctrlWr) ctrlReg <= busWdata[11:0] & CTRL_KEEP;
      if (evt.modeFaultDet) ctrlReg[MASTER_BIT] <= 1'b0;
      if (cntWr) clkCnt <= busWdata[CNT_W-1:0];

      if (evt.wordDone && !doneFlag) begin
        doneFlag <= 1'b1;
        rxData   <= evt.rxWord;
      end else if (dataAcc && seenDone) begin
        doneFlag <= 1'b0;
      end

      if (evt.wordDone && doneFlag) ovrFlag <= 1'b1;
      else if (statusRd)            ovrFlag <= 1'b0;

      if (blockedWr)                  wcolFlag <= 1'b1;
      else if (dataAcc && seenWcol)   wcolFlag <= 1'b0;

      if (evt.slaveAbort) abrtFlag <= 1'b1;
      else if (statusRd)  abrtFlag <= 1'b0;

      if (evt.modeFaultDet)         modfFlag <= 1'b1;
      else if (ctrlWr && seenModf)  modfFlag <= 1'b0;

      if (statusRd) begin
        seenDone <= doneFlag;
        seenWcol <= wcolFlag;
        seenModf <= modfFlag;
      end else begin
        if (dataAcc) begin
          seenDone <= 1'b0;
          seenWcol <= 1'b0;
        end
        if (ctrlWr) seenModf <= 1'b0;
      end
    end
  end

  // R5
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    blockedWr |=> wcolFlag);

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !seenDone) |=> doneFlag);

  // R7
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evt.wordDone && doneFlag) |=> (ovrFlag && $stable(rxData)));

  // R8
  modf_master_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.modeFaultDet |=> (modfFlag && !cfgMaster));
endmodule

// File: rtl/spi_flag_engine.sv
module spi_flag_engine
  import spi_flag_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [1:0]        busAddr,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  output logic              sckOut,
  output logic              mosiOut,
  input  logic              misoIn,
  input  logic              sckIn,
  input  logic              mosiIn,
  output logic              misoOut,
  input  logic              selN
);
  dpStrobe_t         strobe;
  dpEvent_t          evt;
  logic              cfgMaster;
  logic [BITS_W-1:0] cfgBits;
  logic [CNT_W-1:0]  cfgHalf;

  spi_flag_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .evt(evt), .strobe(strobe), .cfgMaster(cfgMaster),
    .cfgBits(cfgBits), .cfgHalf(cfgHalf)
  );

  spi_flag_datapath #(.CNT_W(CNT_W), .SYNC_N(3)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgMaster(cfgMaster),
    .cfgBits(cfgBits), .cfgHalf(cfgHalf), .evt(evt),
    .sckOut(sckOut), .mosiOut(mosiOut), .misoOut(misoOut),
    .misoIn(misoIn), .sckIn(sckIn), .mosiIn(mosiIn), .selN(selN)
  );
endmodule

// File: tb/spi_flag_engine_test.sv
`timescale 1ns/1ps
module spi_flag_engine_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [15:0] busWdata = 16'd0;
  logic [15:0] busRdata;
  logic sckOut, mosiOut, misoIn, misoOut;
  logic sckIn = 1'b0, mosiIn = 1'b0, selN = 1'b1;

  int checks = 0;
  int fails = 0;
  int monCnt = 0;
  int monHigh = 0;
  logic [15:0] monCap = 16'd0;

  always #2.5 clk = ~clk;
  assign misoIn = ~mosiOut;

  spi_flag_engine uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .sckOut(sckOut), .mosiOut(mosiOut), .misoIn(misoIn),
    .sckIn(sckIn), .mosiIn(mosiIn), .misoOut(misoOut), .selN(selN)
  );

  always @(posedge sckOut) begin
    monCap = {monCap[14:0], mosiOut};
    monCnt = monCnt + 1;
  end
  always @(posedge clk) if (sckOut) monHigh = monHigh + 1;

  function automatic int expBits(bit wide, logic [3:0] len);
    if (!wide) return 8;
    if (len == 4'd0) return 16;
    if (len >= 4'd8) return int'(len);
    return 8;
  endfunction

  function automatic int expPeriod(int cc);
    int p;
    p = cc - (cc % 2);
    if (p < 8) p = 8;
    return p;
  endfunction

  function automatic logic [15:0] maskOf(int n);
    return 16'((32'd1 << n) - 1);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    busSel = 1'b1; busRd = 1'b1; busAddr = a;
    #1 v = busRdata;
    @(negedge clk);
    busSel = 1'b0; busRd = 1'b0;
  endtask

  task automatic runMaster(bit wide, logic [3:0] len, int cc, logic [15:0] word);
    logic [15:0] v;
    int n, p, cnt0, hi0;
    logic [15:0] m;
    n = expBits(wide, len);
    p = expPeriod(cc);
    m = maskOf(n);
    busWrite(2'd0, 16'({len, 8'h00}) | 16'h0020 | (wide ? 16'h0004 : 16'h0000));
    busWrite(2'd3, 16'(cc));
    cnt0 = monCnt; hi0 = monHigh;
    busWrite(2'd2, word);
    repeat (n * p - 2) @(negedge clk);
    busRead(2'd1, v);
    check("R2 done not yet", 16'(v[7]), 16'd0);
    busRead(2'd1, v);
    check("R2 done on time", 16'(v[7]), 16'd1);
    busRead(2'd2, v);
    check("R3 rx right aligned", v, ~word & m);
    check("R2 msb first", monCap & m, word & m);
    check("R3 edge count", 16'(monCnt - cnt0), 16'(n));
    check("R4 sck high time", 16'(monHigh - hi0), 16'(n * p / 2));
    busRead(2'd1, v);
    check("R6 done cleared", v, 16'h0000);
  endtask

  task automatic slaveWord(input logic [15:0] word, input int n, output logic [15:0] cap);
    cap = 16'd0;
    for (int i = n - 1; i >= 0; i--) begin
      sckIn = 1'b0; mosiIn = word[i];
      repeat (4) @(negedge clk);
      cap = {cap[14:0], misoOut};
      sckIn = 1'b1;
      repeat (4) @(negedge clk);
    end
    sckIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v, cap;
    int b0;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(2'd1, v); check("R1 status", v, 16'h0000);
    busRead(2'd2, v); check("R1 data", v, 16'h0000);
    busRead(2'd0, v); check("R1 control", v, 16'h0000);
    check("R1 sck idle", 16'(sckOut), 16'd0);

    // directed master cases: R2 R3 R4
    runMaster(1'b0, 4'h0, 0, 16'h00B4);
    runMaster(1'b1, 4'h0, 9, 16'hC35A);
    runMaster(1'b1, 4'hF, 13, 16'h1E67);
    runMaster(1'b1, 4'h3, 10, 16'h0F69);
    runMaster(1'b1, 4'h8, 8, 16'h0081);
    for (int k = 0; k < 6; k++)
      runMaster(1'($urandom % 2), 4'($urandom % 16), int'($urandom % 24), 16'($urandom));

    // R5 / R6 write collision and ordered clearing
    busWrite(2'd0, 16'h0020);
    busWrite(2'd3, 16'd8);
    b0 = monCnt;
    busWrite(2'd2, 16'h0055);
    repeat (3) @(negedge clk);
    busWrite(2'd2, 16'h00AA);
    repeat (8 * 8 + 5) @(negedge clk);
    busWrite(2'd2, 16'h00F0);
    repeat (40) @(negedge clk);
    check("R5 no extra transfer", 16'(monCnt - b0), 16'd8);
    busRead(2'd2, v);
    check("R5 collided writes ignored", v, 16'h00AA);
    busRead(2'd1, v);
    check("R6 flags kept without status read", v, 16'h00C0);
    busRead(2'd2, v);
    busRead(2'd1, v);
    check("R6 flags cleared after pair", v, 16'h0000);

    // R8 mode fault
    busWrite(2'd0, 16'h0020);
    selN = 1'b0;
    repeat (6) @(negedge clk);
    busRead(2'd1, v); check("R8 fault set", v, 16'h0010);
    busRead(2'd0, v); check("R8 master cleared", 16'(v[5]), 16'd0);
    selN = 1'b1;
    repeat (6) @(negedge clk);
    busRead(2'd2, v);
    busRead(2'd1, v); check("R8 data access keeps fault", v, 16'h0010);
    busWrite(2'd0, 16'h0000);
    busRead(2'd1, v); check("R8 cleared by control write", v, 16'h0000);

    // R9 slave receive and transmit
    busWrite(2'd2, 16'h00C3);
    selN = 1'b0;
    repeat (4) @(negedge clk);
    slaveWord(16'h00A5, 8, cap);
    check("R9 miso word", cap, 16'h00C3);
    busRead(2'd1, v); check("R9 done", v, 16'h0080);
    busRead(2'd2, v); check("R9 rx data", v, 16'h00A5);

    // R7 overrun
    slaveWord(16'h003C, 8, cap);
    slaveWord(16'h0071, 8, cap);
    busRead(2'd1, v); check("R7 overrun set", v, 16'h00A0);
    busRead(2'd1, v); check("R7 overrun cleared by read", v, 16'h0080);
    busRead(2'd2, v); check("R7 old data kept", v, 16'h003C);

    // R10 slave abort
    for (int i = 0; i < 3; i++) begin
      sckIn = 1'b0; mosiIn = 1'b1;
      repeat (4) @(negedge clk);
      sckIn = 1'b1;
      repeat (4) @(negedge clk);
    end
    sckIn = 1'b0;
    repeat (4) @(negedge clk);
    selN = 1'b1;
    repeat (6) @(negedge clk);
    busRead(2'd1, v); check("R10 abort set", v, 16'h0008);
    busRead(2'd1, v); check("R10 abort cleared by read", v, 16'h0000);
    selN = 1'b0;
    repeat (4) @(negedge clk);
    slaveWord(16'h005A, 8, cap);
    busRead(2'd1, v); check("R10 word after abort done", v, 16'h0080);
    busRead(2'd2, v); check("R10 count restarted", v, 16'h005A);
    selN = 1'b1;

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule